// File: doc/BRIEF.md
# No-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous SRAM that never needs an idle cycle between a read and a write. Its storage is a small register array of 36-bit words, split into four 9-bit byte lanes. Address, control and byte enables are registered on the rising clock edge. Write data is taken a fixed number of cycles after its command, the same number of cycles that read data needs to appear. Because the two latencies match, a controller can issue read, write, read on consecutive cycles and keep the data bus busy on every cycle.

Two read latencies are offered. In pipelined mode an output register sits in the read path. In flow-through mode that register is bypassed and both pipelines are one cycle shorter. A built-in two-bit burst counter steps through four addresses in either linear or interleaved order. An active-low clock enable freezes the whole block. A sleep input puts the block into a quiet state without losing its contents. Data in and data out are separate buses, and an output-enable flag takes the place of a tristate pin.

Top module: `nbt_sram`

## Requirements
- R1: A load command (advance low) selects the block only when selALow is 0, selBHigh is 1 and selCLow is 0. If any one of the three is inactive, the command is a deselect: it writes nothing and never raises outEn.
- R2: With flowMode 0 (pipelined), a read loaded at clock edge k sets outEn to 1 and drives the addressed word on dataOut from edge k+1 until edge k+2.
- R3: With flowMode 1 (flow-through), a read loaded at edge k sets outEn to 1 and drives the word from edge k until edge k+1.
- R4: Write data is sampled from dataIn at edge k+2 in pipelined mode and at edge k+1 in flow-through mode, where k is the edge of the write command. In the data slot of a write, outEn is 0.
- R5: The byte enables are active low and are registered with each write. Bit i of byteEnN low writes lane i, which is dataIn bits [9i+8:9i]. A write with byteEnN 4'b1111 is an abort and changes no word.
- R6: A continue command (advance 1) after a read or write repeats that operation at the next burst address. Only the two low address bits change. With interleave 0 they go start+n mod 4; with interleave 1 they go start xor n. The fifth access returns to the start address.
- R7: A continue command after a deselect is again a deselect. A continue ignores the three chip enables and writeN.
- R8: While clkEnN is 1, the clock edge is ignored: no pipeline, burst or memory state changes, and dataOut and outEn hold their values.
- R9: Reads and writes may alternate on consecutive edges with no idle cycle. A read issued one edge after a write to the same address returns the newly written lanes in both modes.
- R10: sleepReq sampled high at edge j leaves edge j+1 as a normal edge, and the block is asleep after edge j+1. While asleep, outEn is 0, commands are discarded and stored words are kept. After sleepReq is sampled low at edge m, edge m+1 is still discarded, and edge m+2 accepts commands again.
- R11: While rstN is low and after its release, outEn is 0 and dataOut is 0 until a read reaches its data slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of control state |
| clkEnN | input | 1 | Active-low clock enable; high freezes the block |
| selALow | input | 1 | Chip enable, active low |
| selBHigh | input | 1 | Chip enable, active high |
| selCLow | input | 1 | Chip enable, active low |
| advance | input | 1 | 0 loads a new command, 1 continues the burst |
| writeN | input | 1 | 0 write, 1 read on a load command |
| byteEnN | input | 4 | Active-low per-lane write enables |
| addrIn | input | 6 | Word address on a load command |
| dataIn | input | 36 | Write data, taken in the write data slot |
| flowMode | input | 1 | 1 flow-through, 0 pipelined; change only when idle |
| interleave | input | 1 | 1 interleaved burst order, 0 linear |
| sleepReq | input | 1 | Sleep request, active high |
| dataOut | output | 36 | Read data, zero when not driving |
| outEn | output | 1 | High while dataOut carries read data |

## Verification
Every address is first written and then read back with back-to-back commands in both latency modes. This separates a wrong data slot for reads or writes from a wrong address path. Read-write-read chains that touch the same address on adjacent edges show whether a freshly written word is forwarded into a pipelined read. All sixteen byte-enable patterns, including the abort, show that each lane is written on its own. Bursts of five accesses in each order show the address sequence and the wrap, and stall cycles inside bursts and pending writes show that a frozen edge neither moves data nor drops it. Deselected, enable-faulted and sleeping commands are followed by reads of the addresses they aimed at, which shows that they left the stored words unchanged.

// File: rtl/nbt_sram_pkg.sv
package nbt_sram_pkg;
  localparam int ADDR_W  = 6;
  localparam int LANES   = 4;
  localparam int LANE_W  = 9;
  localparam int DATA_W  = LANES * LANE_W;
  localparam int BURST_W = 2;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } opKind_t;

  // One registered command travelling down the pipeline
  typedef struct packed {
    opKind_t            op;
    logic [ADDR_W-1:0]  addr;
    logic [LANES-1:0]   lanes;   // active-high lanes to write
  } slot_t;

  localparam slot_t IDLE_SLOT = '{op: OP_IDLE, addr: '0, lanes: '0};

  // Strobes from control to datapath
  typedef struct packed {
    logic [LANES-1:0]  wrLanes;
    logic [ADDR_W-1:0] wrAddr;
    logic [ADDR_W-1:0] rdAddr;
    logic              capRead;
    logic              drive;
    logic              fromReg;
  } strobe_t;

  function automatic logic [BURST_W-1:0] burstLow(input logic [BURST_W-1:0] start,
                                                  input logic [BURST_W-1:0] step,
                                                  input logic interleaved);
    return interleaved ? (start ^ step) : (start + step);
  endfunction
endpackage

// File: rtl/nbt_sram_ctrl.sv
module nbt_sram_ctrl import nbt_sram_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              selALow,
  input  logic              selBHigh,
  input  logic              selCLow,
  input  logic              advance,
  input  logic              writeN,
  input  logic [LANES-1:0]  byteEnN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              flowMode,
  input  logic              interleave,
  input  logic              sleepReq,
  output strobe_t           strobe,
  output logic              asleep,
  output logic              sleepPend
);
  logic [1:0]          zzPipe;
  logic                edgeGo;
  logic                chipOn;
  slot_t               s1, s2, nextSlot, phase;
  opKind_t             lastOp;
  logic [ADDR_W-1:0]   baseAddr, nextBase;
  logic [BURST_W-1:0]  burstCnt, nextCnt;

  assign asleep    = zzPipe[1];
  assign sleepPend = zzPipe[0];
  assign edgeGo    = !clkEnN && !asleep;
  assign chipOn    = !selALow && selBHigh && !selCLow;

  // Command decode: load or continue
  always_comb begin
    nextSlot = IDLE_SLOT;
    nextBase = baseAddr;
    nextCnt  = burstCnt;
    if (!advance) begin
      nextBase      = addrIn;
      nextCnt       = '0;
      nextSlot.addr = addrIn;
      if (chipOn) nextSlot.op = writeN ? OP_READ : OP_WRITE;
    end else begin
      nextSlot.op = lastOp;
      if (lastOp != OP_IDLE) nextCnt = burstCnt + 1'b1;
      nextSlot.addr = {baseAddr[ADDR_W-1:BURST_W],
                       burstLow(baseAddr[BURST_W-1:0], nextCnt, interleave)};
    end
    if (nextSlot.op == OP_WRITE) nextSlot.lanes = ~byteEnN;
  end

  // Sleep entry and exit delay
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) zzPipe <= '0;
    else       zzPipe <= {zzPipe[0], sleepReq};
  end

  // Command pipeline and burst state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1       <= IDLE_SLOT;
      s2       <= IDLE_SLOT;
      lastOp   <= OP_IDLE;
      baseAddr <= '0;
      burstCnt <= '0;
    end else if (asleep) begin
      s1     <= IDLE_SLOT;
      s2     <= IDLE_SLOT;
      lastOp <= OP_IDLE;
    end else if (!clkEnN) begin
      s1       <= nextSlot;
      s2       <= s1;
      lastOp   <= nextSlot.op;
      baseAddr <= nextBase;
      burstCnt <= nextCnt;
    end
  end

  // Data slot: stage one in flow-through, stage two in pipelined mode
  assign phase = flowMode ? s1 : s2;

  always_comb begin
    strobe.wrLanes = (edgeGo && phase.op == OP_WRITE) ? phase.lanes : '0;
    strobe.wrAddr  = phase.addr;
    strobe.rdAddr  = s1.addr;
    strobe.capRead = edgeGo && !flowMode && (s1.op == OP_READ);
    strobe.drive   = !asleep && (phase.op == OP_READ);
    strobe.fromReg = !flowMode;
  end
endmodule

// File: rtl/nbt_sram_dp.sv
module nbt_sram_dp import nbt_sram_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              outEn
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] rdWord;
  logic [DATA_W-1:0] doutReg;
  logic              sameAddr;

  assign sameAddr = (strobe.wrAddr == strobe.rdAddr);

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic              fwd;

    always_ff @(posedge clk) begin
      if (strobe.wrLanes[g]) laneMem[strobe.wrAddr] <= dataIn[g*LANE_W +: LANE_W];
    end

    // Forward a lane being written on this edge into a read captured on it
    assign fwd = strobe.wrLanes[g] && sameAddr;
    assign rdWord[g*LANE_W +: LANE_W] = fwd ? dataIn[g*LANE_W +: LANE_W]
                                            : laneMem[strobe.rdAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               doutReg <= '0;
    else if (strobe.capRead) doutReg <= rdWord;
  end

  assign outEn   = strobe.drive;
  assign dataOut = strobe.drive ? (strobe.fromReg ? doutReg : rdWord) : '0;
endmodule

// File: rtl/nbt_sram.sv
module nbt_sram import nbt_sram_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              selALow,
  input  logic              selBHigh,
  input  logic              selCLow,
  input  logic              advance,
  input  logic              writeN,
  input  logic [LANES-1:0]  byteEnN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              flowMode,
  input  logic              interleave,
  input  logic              sleepReq,
  output logic [DATA_W-1:0] dataOut,
  output logic              outEn
);
  strobe_t strobe;
  logic    asleep;
  logic    sleepPend;

  nbt_sram_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .clkEnN    (clkEnN),
    .selALow   (selALow),
    .selBHigh  (selBHigh),
    .selCLow   (selCLow),
    .advance   (advance),
    .writeN    (writeN),
    .byteEnN   (byteEnN),
    .addrIn    (addrIn),
    .flowMode  (flowMode),
    .interleave(interleave),
    .sleepReq  (sleepReq),
    .strobe    (strobe),
    .asleep    (asleep),
    .sleepPend (sleepPend)
  );

  nbt_sram_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .dataIn (dataIn),
    .dataOut(dataOut),
    .outEn  (outEn)
  );
endmodule

// File: rtl/nbt_sram_chk.sv
module nbt_sram_chk import nbt_sram_pkg::*; (
  input logic              clk,
  input logic              rstN,
  input logic              clkEnN,
  input logic              selALow,
  input logic              selBHigh,
  input logic              selCLow,
  input logic              advance,
  input logic              writeN,
  input logic              flowMode,
  input logic [DATA_W-1:0] dataOut,
  input logic              outEn,
  input logic              asleep,
  input logic              sleepPend
);
  logic go, chipOn, loadRead, loadWrite, loadDesel;
  assign go        = !clkEnN && !asleep && !sleepPend;
  assign chipOn    = !selALow && selBHigh && !selCLow;
  assign loadRead  = !advance && chipOn && writeN;
  assign loadWrite = !advance && chipOn && !writeN;
  assign loadDesel = !advance && !chipOn;

  a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (flowMode && go && loadDesel) |=> !outEn);

  a_r2_pipe_read_slot: assert property (@(posedge clk) disable iff (!rstN)
    (!flowMode && go && loadRead) ##1 go |=> outEn);

  a_r3_flow_read_slot: assert property (@(posedge clk) disable iff (!rstN)
    (flowMode && go && loadRead) |=> outEn);

  a_r4_flow_write_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (flowMode && go && loadWrite) |=> !outEn);

  a_r4_pipe_write_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!flowMode && go && loadWrite) ##1 go |=> !outEn);

  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    (clkEnN && !asleep && !sleepPend) |=> ($stable(outEn) && $stable(dataOut)));

  a_r10_sleep_silent: assert property (@(posedge clk) disable iff (!rstN)
    asleep |-> (!outEn && dataOut == '0));
endmodule

bind nbt_sram nbt_sram_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .clkEnN   (clkEnN),
  .selALow  (selALow),
  .selBHigh (selBHigh),
  .selCLow  (selCLow),
  .advance  (advance),
  .writeN   (writeN),
  .flowMode (flowMode),
  .dataOut  (dataOut),
  .outEn    (outEn),
  .asleep   (asleep),
  .sleepPend(sleepPend)
);

// File: tb/tb_nbt_sram.sv
module tb_nbt_sram;
  import nbt_sram_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int MAXC       = 200;
  localparam int K_DESEL = 0, K_READ = 1, K_WRITE = 2, K_CONT = 3, K_BADSEL = 4;

  logic clk = 0, rstN = 0, clkEnN = 0;
  logic selALow = 1, selBHigh = 0, selCLow = 1;
  logic advance = 0, writeN = 1;
  logic [LANES-1:0]  byteEnN = '1;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [DATA_W-1:0] dataIn = '0;
  logic interleave = 0, flowMode = 0, sleepReq = 0;
  logic [DATA_W-1:0] dataOut;
  logic              outEn;

  int checks = 0, errors = 0;
  bit done = 0;
  int nCmd = 0, batch = 0;

  logic [DATA_W-1:0] refMem [DEPTH];
  int                cKind [MAXC];
  logic [ADDR_W-1:0] cAddr [MAXC];
  logic [LANES-1:0]  cBen  [MAXC];
  bit                cStall[MAXC];
  string             cTag  [MAXC];
  int                eOp   [MAXC];
  logic [ADDR_W-1:0] eAddr [MAXC];
  logic [DATA_W-1:0] eData [MAXC];

  nbt_sram dut (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN),
    .selALow(selALow), .selBHigh(selBHigh), .selCLow(selCLow),
    .advance(advance), .writeN(writeN), .byteEnN(byteEnN),
    .addrIn(addrIn), .dataIn(dataIn), .flowMode(flowMode),
    .interleave(interleave), .sleepReq(sleepReq),
    .dataOut(dataOut), .outEn(outEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DATA_W-1:0] pat(int n, int salt);
    longint v;
    v = (longint'(n) * 64'd2654435761) ^ (longint'(salt) << 13) ^ 64'h5_A5A5_A5A5;
    return v[DATA_W-1:0];
  endfunction

  task automatic chk(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chkBit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // on=1: all three enables active; otherwise one of them inactive, chosen by v
  task automatic setSel(bit on, int v);
    selALow = 0; selBHigh = 1; selCLow = 0;
    if (!on) begin
      case (v % 3)
        0: selALow = 1;
        1: selBHigh = 0;
        default: selCLow = 1;
      endcase
    end
  endtask

  task automatic drv(bit adv, bit wn, bit on, logic [ADDR_W-1:0] a, logic [LANES-1:0] b, int v);
    advance = adv; writeN = wn; addrIn = a; byteEnN = b;
    setSel(on, v);
  endtask

  task automatic add(int k, logic [ADDR_W-1:0] a, logic [LANES-1:0] b, bit st, string t);
    cKind[nCmd] = k; cAddr[nCmd] = a; cBen[nCmd] = b; cStall[nCmd] = st; cTag[nCmd] = t;
    nCmd++;
  endtask

  task automatic applyInputs(int i);
    if (i >= nCmd) drv(0, 1, 0, '0, '1, i);
    else begin
      case (cKind[i])
        K_READ:   drv(0, 1, 1, cAddr[i], '1, i);
        K_WRITE:  drv(0, 0, 1, cAddr[i], cBen[i], i);
        K_CONT:   drv(1, i[0], (i % 2) == 0, ADDR_W'(i * 7), cBen[i], i);
        K_BADSEL: drv(0, 0, 0, cAddr[i], '0, i);
        default:  drv(0, 1, 0, cAddr[i], '1, i);
      endcase
    end
  endtask

  task automatic runSched();
    int lastOp;
    logic [ADDR_W-1:0] base;
    logic [1:0] cnt, low;
    int wl, rl;
    logic [DATA_W-1:0] prevOut;
    logic prevEn;
    wl = flowMode ? 1 : 2;
    rl = flowMode ? 0 : 1;
    lastOp = K_DESEL; base = '0; cnt = '0;
    // Expected operation and address of each command (R6, R7, R1)
    for (int i = 0; i < nCmd; i++) begin
      case (cKind[i])
        K_READ, K_WRITE: begin
          eOp[i] = cKind[i]; base = cAddr[i]; cnt = '0; eAddr[i] = cAddr[i];
        end
        K_CONT: begin
          eOp[i] = lastOp;
          if (lastOp != K_DESEL) cnt = cnt + 2'd1;
          low = interleave ? (base[1:0] ^ cnt) : (base[1:0] + cnt);
          eAddr[i] = {base[ADDR_W-1:2], low};
        end
        default: begin eOp[i] = K_DESEL; eAddr[i] = cAddr[i]; end
      endcase
      lastOp = eOp[i];
      eData[i] = pat(i + batch * 1000, 7);
    end
    prevOut = dataOut; prevEn = outEn;
    for (int i = 0; i < nCmd + 3; i++) begin
      int jw, jr;
      jw = i - wl; jr = i - rl;
      if (i < nCmd && cStall[i]) begin
        applyInputs(i); clkEnN = 1; dataIn = ~pat(i, 3);
        tick();
        chkBit($sformatf("R8 stall holds outEn before cmd %0d", i), outEn, prevEn);
        chk($sformatf("R8 stall holds dataOut before cmd %0d", i), dataOut, prevOut);
        clkEnN = 0;
      end
      applyInputs(i);
      if (jw >= 0 && jw < nCmd && eOp[jw] == K_WRITE) dataIn = eData[jw];
      else dataIn = ~pat(i, 5);
      tick();
      if (jw >= 0 && jw < nCmd && eOp[jw] == K_WRITE)
        for (int l = 0; l < LANES; l++)
          if (!cBen[jw][l])
            refMem[eAddr[jw]][l*LANE_W +: LANE_W] = eData[jw][l*LANE_W +: LANE_W];
      if (jr >= 0 && jr < nCmd) begin
        if (eOp[jr] == K_READ) begin
          chkBit($sformatf("%s %s outEn cmd %0d", flowMode ? "R3" : "R2", cTag[jr], jr), outEn, 1'b1);
          chk($sformatf("%s %s data cmd %0d", flowMode ? "R3" : "R2", cTag[jr], jr),
              dataOut, refMem[eAddr[jr]]);
        end else begin
          chkBit($sformatf("%s %s no drive cmd %0d", (eOp[jr] == K_WRITE) ? "R4" : "R1",
                           cTag[jr], jr), outEn, 1'b0);
        end
      end
      prevOut = dataOut; prevEn = outEn;
    end
    nCmd = 0;
    batch++;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired got running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R11: quiet output in and after reset
    repeat (3) tick();
    chkBit("R11 outEn in reset", outEn, 1'b0);
    chk("R11 dataOut in reset", dataOut, '0);
    rstN = 1;
    tick();
    chkBit("R11 outEn after reset", outEn, 1'b0);
    chk("R11 dataOut after reset", dataOut, '0);

    for (int m = 0; m < 2; m++) begin
      flowMode = (m == 1);
      interleave = 0;
      tick();
      // Exhaustive write then read sweep (R4)
      for (int a = 0; a < DEPTH; a++) add(K_WRITE, ADDR_W'(a), '0, 0, "R4");
      runSched();
      for (int a = 0; a < DEPTH; a++) add(K_READ, ADDR_W'(a), '1, (a % 9) == 4, "R4");
      runSched();
      // Read-write-read with same-address forwarding and stalls (R9, R8)
      for (int k = 0; k < 12; k++) begin
        add(K_WRITE, ADDR_W'(16 + k), '0, (k % 4) == 1, "R9");
        add(K_READ,  ADDR_W'(16 + k), '1, 0, "R9");
        add(K_WRITE, ADDR_W'(32 + k), '0, (k % 5) == 2, "R9");
        add(K_READ,  ADDR_W'(k), '1, 0, "R9");
      end
      runSched();
      // Every byte-enable pattern, including the abort (R5)
      for (int b = 0; b < 16; b++) begin
        add(K_WRITE, ADDR_W'(32 + b), LANES'(b), 0, "R5");
        add(K_READ,  ADDR_W'(32 + b), '1, 0, "R5");
      end
      runSched();
      // Bursts in both orders with wrap (R6)
      for (int il = 0; il < 2; il++) begin
        interleave = (il == 1);
        add(K_WRITE, ADDR_W'(9 + il * 40), '0, 0, "R6");
        for (int c = 0; c < 5; c++) add(K_CONT, '0, '0, c == 2, "R6");
        add(K_READ, ADDR_W'(9 + il * 40), '1, 0, "R6");
        for (int c = 0; c < 5; c++) add(K_CONT, '0, '1, c == 3, "R6");
        runSched();
      end
      interleave = 0;
      // Deselect chains and enable faults (R7, R1)
      add(K_DESEL, 6'd3, '1, 0, "R1");
      add(K_CONT, '0, '0, 0, "R7");
      add(K_CONT, '0, '0, 0, "R7");
      add(K_BADSEL, 6'd3, '0, 0, "R1");
      add(K_BADSEL, 6'd3, '0, 0, "R1");
      add(K_BADSEL, 6'd3, '0, 0, "R1");
      add(K_READ, 6'd3, '1, 0, "R1");
      add(K_CONT, '0, '1, 0, "R7");
      add(K_CONT, '0, '1, 0, "R7");
      runSched();
    end

    // R10: sleep entry and exit timing in flow-through mode
    drv(0, 1, 1, 6'd0, '1, 0); sleepReq = 1;
    tick();
    chkBit("R10 first edge after request still normal", outEn, 1'b1);
    chk("R10 first edge data", dataOut, refMem[0]);
    drv(0, 1, 1, 6'd1, '1, 0);
    tick();
    chkBit("R10 asleep after second edge", outEn, 1'b0);
    for (int s = 0; s < 3; s++) begin
      drv(0, 0, 1, 6'd1, '0, 0); dataIn = ~refMem[1];
      tick();
      chkBit("R10 no drive while asleep", outEn, 1'b0);
    end
    sleepReq = 0;
    drv(0, 1, 1, 6'd1, '1, 0);
    tick();
    chkBit("R10 wake edge m discarded", outEn, 1'b0);
    tick();
    chkBit("R10 wake edge m+1 discarded", outEn, 1'b0);
    tick();
    chkBit("R10 read accepted after wake", outEn, 1'b1);
    chk("R10 contents kept through sleep", dataOut, refMem[1]);
    drv(0, 1, 0, '0, '1, 0);
    tick();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule